// File: doc/BRIEF.md
# Accumulator Readout Window Unit

This block reads a full pass of bins out of a 512-entry accumulator memory and turns each 24-bit bin into a 9-bit result. One pulse on `start` latches the readout settings and begins the pass. The unit then issues one read address per cycle, from 0 up to 511, to a synchronous RAM that returns data one cycle later.

Each returned bin goes through three steps. First, an optional running sum replaces the bin with the total of all bins read so far in the pass; this is the form needed for a histogram-equalization transfer function. Second, a 4-bit window select keeps nine consecutive bits of the value. Third, an optional clamp forces the result to 511 when any bit above the window is set. Each result goes either to a data output, tagged with its bin index, or to a lookup-table write port that carries a 2-bit table number.

Top module: `acc_readout_top`

## Requirements
- R1: After reset, `ram_rd_en`, `dout_valid`, `lut_we` and `busy` are all 0.
- R2: A `start` pulse while idle makes `ram_rd_en` high for exactly 512 consecutive cycles, with `ram_addr` stepping 0, 1, ... 511, and then low.
- R3: The result for address k appears exactly two cycles after the cycle in which `ram_addr` = k with `ram_rd_en` high, tagged with index k (`dout_idx` or `lut_addr`).
- R4: With select value s (0..15), the result is bits s through s+8 of the processed value (s=0 gives bits 0..8).
- R5: With the clamp enabled, the result is 511 whenever any processed-value bit from s+9 to 23 is 1.
- R6: With the clamp disabled, the selected nine bits pass unchanged even when higher bits are set.
- R7: With s=15 no bits lie above the window, so the clamp never alters the result.
- R8: With the running-sum mode on, the processed value is the 24-bit wrapping sum of the bins 0..k of the current pass; the sum restarts at zero on every pass.
- R9: With the running-sum mode off, the processed value is the bin itself.
- R10: Destination 0 drives `dout`/`dout_valid`; destination 1 drives `lut_we`/`lut_addr`/`lut_data` with `lut_bank` equal to the latched table number. The two strobes are never high together.
- R11: The settings are latched when a pass starts. Changes to the `cfg_*` inputs, and `start` pulses, while `busy` is high have no effect on the pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a readout pass (ignored while busy) |
| cfg_sel | input | 4 | Window select s |
| cfg_sat | input | 1 | Clamp enable |
| cfg_eq | input | 1 | Running-sum enable |
| cfg_dest | input | 1 | 0 = data output, 1 = lookup-table write |
| cfg_bank | input | 2 | Lookup-table number for writes |
| ram_rd_en | output | 1 | Accumulator memory read enable |
| ram_addr | output | 9 | Accumulator memory read address |
| ram_rdata | input | 24 | Bin data, valid one cycle after the read |
| dout | output | 9 | Result on the data output |
| dout_idx | output | 9 | Bin index of `dout` |
| dout_valid | output | 1 | `dout` strobe |
| lut_we | output | 1 | Lookup-table write strobe |
| lut_bank | output | 2 | Lookup-table number |
| lut_addr | output | 9 | Lookup-table write address (bin index) |
| lut_data | output | 9 | Lookup-table write data |
| busy | output | 1 | Pass in progress |

## Verification
The assertions check the timing skeleton on every cycle: addresses step by one while reads continue, reads stop after address 511, every read produces a strobe two cycles later, the two strobes exclude each other, and the latched settings hold steady through a pass. The arithmetic content of each result can only be shown by the bench's scenarios. These are the window position for all sixteen select values, the clamp with and without high bits, the s=15 boundary, the running sum and its restart, the routing, and interference from the inputs during a pass. Each is compared with values the bench computes from the memory contents.

// File: rtl/acc_rd_pkg.sv
package acc_rd_pkg;
  localparam int SEL_W  = 4;
  localparam int BANK_W = 2;

  typedef enum logic {
    DEST_DOUT = 1'b0,
    DEST_LUT  = 1'b1
  } dest_e;

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic              sat;
    logic              eq;
    dest_e             dest;
    logic [BANK_W-1:0] bank;
  } mode_t;
endpackage

// File: rtl/acc_rd_seq.sv
// Pass sequencer: one read address per cycle from 0 up to DEPTH-1.
module acc_rd_seq #(
  parameter int ADDR_W = 9,
  parameter int DEPTH  = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  output logic              rd_en,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic              run_q, run_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              upd;

  always_comb begin
    run_d  = run_q;
    addr_d = addr_q;
    upd    = 1'b0;
    if (!run_q) begin
      if (go) begin
        run_d  = 1'b1;
        addr_d = '0;
        upd    = 1'b1;
      end
    end else begin
      upd = 1'b1;
      if (addr_q == LAST) begin
        run_d = 1'b0;
      end else begin
        addr_d = addr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      addr_q <= '0;
    end else if (upd) begin
      run_q  <= run_d;
      addr_q <= addr_d;
    end
  end

  assign rd_en = run_q;
  assign addr  = addr_q;
endmodule

// File: rtl/acc_eq_sum.sv
// Optional running sum of the bins in the current pass.
module acc_eq_sum #(
  parameter int BIN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             eq,
  input  logic [BIN_W-1:0] bin,
  output logic [BIN_W-1:0] val
);
  logic [BIN_W-1:0] sum_q, sum_d, total;
  logic             ld;

  always_comb begin
    total = sum_q + bin;
    val   = eq ? total : bin;
    ld    = clr | (en & eq);
    sum_d = clr ? '0 : total;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
    end else if (ld) begin
      sum_q <= sum_d;
    end
  end
endmodule

// File: rtl/acc_win_sat.sv
// Window selection and optional clamp on the bits above the window.
module acc_win_sat #(
  parameter int BIN_W = 24,
  parameter int OUT_W = 9,
  parameter int SEL_W = 4
) (
  input  logic [BIN_W-1:0] val,
  input  logic [SEL_W-1:0] sel,
  input  logic             sat,
  output logic [OUT_W-1:0] res
);
  logic [BIN_W-1:0] shifted;
  logic [OUT_W-1:0] win;
  logic             hi;

  always_comb begin
    shifted = val >> sel;
    win     = shifted[OUT_W-1:0];
    hi      = 1'b0;
    for (int i = 0; i < BIN_W; i++) begin
      if (i >= int'(sel) + OUT_W) hi = hi | val[i];
    end
    res = (sat && hi) ? {OUT_W{1'b1}} : win;
  end
endmodule

// File: rtl/acc_readout_top.sv
module acc_readout_top
  import acc_rd_pkg::*;
#(
  parameter int BIN_W  = 24,
  parameter int OUT_W  = 9,
  parameter int ADDR_W = 9,
  parameter int DEPTH  = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic              cfg_sat,
  input  logic              cfg_eq,
  input  logic              cfg_dest,
  input  logic [BANK_W-1:0] cfg_bank,
  output logic              ram_rd_en,
  output logic [ADDR_W-1:0] ram_addr,
  input  logic [BIN_W-1:0]  ram_rdata,
  output logic [OUT_W-1:0]  dout,
  output logic [ADDR_W-1:0] dout_idx,
  output logic              dout_valid,
  output logic              lut_we,
  output logic [BANK_W-1:0] lut_bank,
  output logic [ADDR_W-1:0] lut_addr,
  output logic [OUT_W-1:0]  lut_data,
  output logic              busy
);
  mode_t             mode_q, mode_d;
  logic              go;
  logic              v1_q;
  logic [ADDR_W-1:0] a1_q;
  logic [BIN_W-1:0]  val;
  logic [OUT_W-1:0]  res;

  // start is taken only when the whole pipeline is idle
  assign go   = start & ~ram_rd_en & ~v1_q;
  assign busy = ram_rd_en | v1_q;

  always_comb begin
    mode_d.sel  = cfg_sel;
    mode_d.sat  = cfg_sat;
    mode_d.eq   = cfg_eq;
    mode_d.dest = dest_e'(cfg_dest);
    mode_d.bank = cfg_bank;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (go) begin
      mode_q <= mode_d;
    end
  end

  acc_rd_seq #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (go),
    .rd_en (ram_rd_en),
    .addr  (ram_addr)
  );

  // data-return stage aligned with the one-cycle RAM latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      a1_q <= '0;
    end else begin
      v1_q <= ram_rd_en;
      if (ram_rd_en) a1_q <= ram_addr;
    end
  end

  acc_eq_sum #(.BIN_W(BIN_W)) u_sum (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (go),
    .en    (v1_q),
    .eq    (mode_q.eq),
    .bin   (ram_rdata),
    .val   (val)
  );

  acc_win_sat #(.BIN_W(BIN_W), .OUT_W(OUT_W), .SEL_W(SEL_W)) u_win (
    .val (val),
    .sel (mode_q.sel),
    .sat (mode_q.sat),
    .res (res)
  );

  // output router
  logic              dv_d, we_d, out_ld, dres_ld, lres_ld;
  always_comb begin
    dv_d    = v1_q & (mode_q.dest == DEST_DOUT);
    we_d    = v1_q & (mode_q.dest == DEST_LUT);
    out_ld  = v1_q | dout_valid | lut_we;
    dres_ld = dv_d;
    lres_ld = we_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_valid <= 1'b0;
      lut_we     <= 1'b0;
    end else if (out_ld) begin
      dout_valid <= dv_d;
      lut_we     <= we_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout     <= '0;
      dout_idx <= '0;
    end else if (dres_ld) begin
      dout     <= res;
      dout_idx <= a1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lut_data <= '0;
      lut_addr <= '0;
      lut_bank <= '0;
    end else if (lres_ld) begin
      lut_data <= res;
      lut_addr <= a1_q;
      lut_bank <= mode_q.bank;
    end
  end
endmodule

// File: rtl/acc_readout_chk.sv
module acc_readout_chk
  import acc_rd_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DEPTH  = 512
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ram_rd_en,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              dout_valid,
  input logic              lut_we,
  input logic              busy,
  input mode_t             mode_q
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  // R2: consecutive reads step the address by one
  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_rd_en && $past(ram_rd_en)) |-> (ram_addr == $past(ram_addr) + 1'b1));

  // R2: reading stops after the last bin
  a_r2_stop_at_last: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_rd_en && ram_addr == LAST) |=> !ram_rd_en);

  // R3: every read yields a strobe two cycles later
  a_r3_strobe_latency: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd_en |=> ##1 (dout_valid || lut_we));

  // R10: the two destinations never strobe together
  a_r10_one_dest: assert property (@(posedge clk) disable iff (!rst_n)
    !(dout_valid && lut_we));

  // R11: latched settings hold while a pass runs
  a_r11_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mode_q));
endmodule

bind acc_readout_top acc_readout_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ram_rd_en  (ram_rd_en),
  .ram_addr   (ram_addr),
  .dout_valid (dout_valid),
  .lut_we     (lut_we),
  .busy       (busy),
  .mode_q     (mode_q)
);

// File: tb/sim_acc_readout_top.sv
`timescale 1ns/1ps
module sim_acc_readout_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic        cfg_sat = 1'b0, cfg_eq = 1'b0, cfg_dest = 1'b0;
  logic [1:0]  cfg_bank = '0;
  logic        ram_rd_en;
  logic [8:0]  ram_addr;
  logic [23:0] ram_rdata = '0;
  logic [8:0]  dout, dout_idx, lut_addr, lut_data;
  logic        dout_valid, lut_we, busy;
  logic [1:0]  lut_bank;

  int checks = 0;
  int errors = 0;
  logic [23:0] mem [512];

  always #4 clk = ~clk;

  acc_readout_top u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_sel(cfg_sel), .cfg_sat(cfg_sat), .cfg_eq(cfg_eq),
    .cfg_dest(cfg_dest), .cfg_bank(cfg_bank),
    .ram_rd_en(ram_rd_en), .ram_addr(ram_addr), .ram_rdata(ram_rdata),
    .dout(dout), .dout_idx(dout_idx), .dout_valid(dout_valid),
    .lut_we(lut_we), .lut_bank(lut_bank), .lut_addr(lut_addr),
    .lut_data(lut_data), .busy(busy)
  );

  always @(posedge clk) if (ram_rd_en) ram_rdata <= mem[ram_addr];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model(input logic [23:0] v, input int s, input bit sat);
    logic [31:0] w;
    w = {8'h0, v};
    if (sat && ((w >> (s + 9)) != 0)) return 511;
    return int'((w >> s) & 32'h1FF);
  endfunction

  // One full pass; disturb changes cfg inputs and pulses start mid-pass (R11)
  task automatic run_pass(input int s, input bit sat, input bit eq, input bit dest,
                          input int bank, input bit disturb, input string tag);
    int got = 0, rd = 0, cyc = 0, bad = 0;
    int rd_cyc[512];
    logic [23:0] sum = '0;
    int exp_v[512];
    for (int i = 0; i < 512; i++) begin
      sum = sum + mem[i];
      exp_v[i] = model(eq ? sum : mem[i], s, sat);
    end
    @(negedge clk);
    cfg_sel = 4'(s); cfg_sat = sat; cfg_eq = eq; cfg_dest = dest; cfg_bank = 2'(bank);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while ((got < 512 || busy) && cyc < 1200) begin
      if (disturb && cyc == 100) begin
        cfg_sel = ~cfg_sel; cfg_sat = ~cfg_sat; cfg_eq = ~cfg_eq;
        cfg_dest = ~cfg_dest; cfg_bank = ~cfg_bank; start = 1'b1;
      end
      if (disturb && cyc == 101) start = 1'b0;
      if (ram_rd_en) begin
        if (rd < 512) rd_cyc[rd] = cyc;
        if (ram_addr != 9'(rd)) begin bad++; chk(0, "R2 addr", int'(ram_addr), rd); end
        rd++;
      end
      if (dout_valid || lut_we) begin
        int idx = dest ? int'(lut_addr) : int'(dout_idx);
        int val = dest ? int'(lut_data) : int'(dout);
        if (got < 512) begin
          if ((dest && !lut_we) || (!dest && !dout_valid) || (dout_valid && lut_we)) begin
            bad++; chk(0, {"R10 route ", tag}, int'(lut_we), int'(dest));
          end
          if (dest && lut_bank != 2'(bank)) begin
            bad++; chk(0, {"R10 bank ", tag}, int'(lut_bank), bank);
          end
          if (idx != got || cyc != rd_cyc[got] + 2) begin
            bad++; chk(0, {"R3 index/latency ", tag}, idx, got);
          end
          if (val != exp_v[got]) begin
            bad++; chk(0, {"R4-value ", tag}, val, exp_v[got]);
          end
        end
        got++;
      end
      @(negedge clk);
      cyc++;
    end
    chk(rd == 512, {"R2 read count ", tag}, rd, 512);
    chk(got == 512, {"R3 result count ", tag}, got, 512);
    chk(bad == 0, {"pass content ", tag}, bad, 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(!ram_rd_en && !dout_valid && !lut_we && !busy, {"R2 quiet after pass ", tag},
          int'(ram_rd_en), 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 512; i++) begin
      logic [31:0] h;
      h = (i + 1) * 32'h9E3779B1;
      h = h ^ (h >> 7);
      mem[i] = (i % 4 == 0) ? 24'(h >> (8 + i % 24)) : 24'(h);
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!ram_rd_en && !dout_valid && !lut_we && !busy, "R1 reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ram_rd_en && !dout_valid && !lut_we && !busy, "R1 after release", int'(busy), 0);

    // R4 R5 R6 R7 R9: every window, clamp off and on, raw bins
    for (int s = 0; s < 16; s++) begin
      run_pass(s, 1'b0, 1'b0, 1'b0, 0, 1'b0, "R4_R6_R9 window");
      run_pass(s, 1'b1, 1'b0, 1'b0, 0, 1'b0, s == 15 ? "R7 top window" : "R5 clamp");
    end
    // R8: running sum, restarted each pass
    run_pass(0, 1'b1, 1'b1, 1'b0, 0, 1'b0, "R8 sum clamp s0");
    run_pass(0, 1'b1, 1'b1, 1'b0, 0, 1'b0, "R8 sum restart");
    run_pass(7, 1'b0, 1'b1, 1'b0, 0, 1'b0, "R8 sum s7");
    run_pass(15, 1'b1, 1'b1, 1'b0, 0, 1'b0, "R8 sum s15");
    // R10: lookup-table routing with table numbers
    run_pass(3, 1'b1, 1'b0, 1'b1, 2, 1'b0, "R10 lut bank2");
    run_pass(12, 1'b0, 1'b1, 1'b1, 1, 1'b0, "R10 lut eq bank1");
    // R11: inputs toggled and start pulsed mid-pass
    run_pass(5, 1'b0, 1'b0, 1'b0, 0, 1'b1, "R11 disturb dout");
    run_pass(9, 1'b1, 1'b1, 1'b1, 3, 1'b1, "R11 disturb lut");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule